// File: doc/BRIEF.md
# Conditional Jump Evaluator

This block settles whether a conditional relative jump in a small 16-bit microcontroller core is taken, and produces the program counter that follows. It takes a 3-bit condition code, the status register, the address of the instruction after the jump, and the jump's signed 10-bit word offset. It returns a taken flag, the next PC and a self-loop flag. The self-loop flag rises when a taken jump lands on its own address, so a debugger or a testbench can see that the core has parked in an idle loop.

The inputs are captured on a rising clock edge. The three outputs are registered, so they show the result one cycle later. Fetch, decode of the other instruction formats and pipeline flushing are handled by the core around this block.

Top module: `jmp_eval`

## Requirements
- R1: While reset is asserted, and after it is released but before the first rising edge, taken_o, self_loop_o and pc_o are all zero.
- R2: Each output is registered. After rising edge t it shows the result for the inputs present at edge t, and it holds that value until the next edge.
- R3: Code 0 (not equal) is taken when status bit 1 (Z) is 0. Code 1 (equal) is taken when Z is 1.
- R4: Code 2 (no carry) is taken when status bit 0 (C) is 0. Code 3 (carry) is taken when C is 1.
- R5: Code 4 (negative) is taken when status bit 2 (N) is 1.
- R6: Code 5 (greater or equal) is taken when N equals status bit 8 (V). Code 6 (less) is taken when N differs from V.
- R7: Code 7 is always taken.
- R8: When the jump is taken, pc_o equals pc_next_i plus twice the two's-complement 10-bit offset, modulo 2^16.
- R9: When the jump is not taken, pc_o equals pc_next_i.
- R10: self_loop_o is 1 exactly when the jump is taken and its target equals pc_next_i minus 2, modulo 2^16. That target is the jump's own address.
- R11: Status bits other than 0, 1, 2 and 8 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | 3 | Condition code, 0 to 7 |
| status_i | input | 16 | Status register with the C, Z, N and V flags |
| pc_next_i | input | 16 | Address of the instruction after the jump |
| offset_i | input | 10 | Signed word offset from the instruction |
| taken_o | output | 1 | Jump taken |
| pc_o | output | 16 | Next program counter |
| self_loop_o | output | 1 | Taken jump whose target is its own address |

## Verification
The bench drives each condition code with its deciding flag both set and clear. A design that swapped the two polarities, or read the wrong status bit, would take the jump on the wrong branch. For the two signed conditions, the bench covers all four combinations of N and V, which catches a design that tests N alone.

The offset extremes -512 and +511 are applied, together with targets that wrap past 0xFFFF and below 0x0000. A sign-extension fault would send these jumps to distant addresses, and a missing wrap would corrupt the upper bits of the PC.

An offset of -1 is applied both taken and not taken. A design that raised the self-loop flag without checking taken, or that compared the target against the wrong address, would flag idle loops that do not exist or miss ones that do.

Finally, the bench sets every status bit outside the four flags. A design that decoded the wrong bit positions would then change its decisions.

// File: rtl/jmp_eval_pkg.sv
package jmp_eval_pkg;

   // Condition code encoding. The numeric order is what the instruction field holds.
   typedef enum logic [2:0] {
      JC_NE  = 3'd0,
      JC_EQ  = 3'd1,
      JC_NC  = 3'd2,
      JC_CS  = 3'd3,
      JC_NEG = 3'd4,
      JC_GE  = 3'd5,
      JC_LT  = 3'd6,
      JC_ALW = 3'd7
   } jcond_e;

   // The four arithmetic flags, pulled out of the status word.
   typedef struct packed {
      logic v;
      logic n;
      logic z;
      logic c;
   } jflags_t;

   // Bytes per jump instruction: one 16-bit word.
   localparam int unsigned JMP_INSN_BYTES = 2;

endpackage

// File: rtl/jmp_cond_decode.sv
module jmp_cond_decode #(
   parameter int unsigned SR_W  = 16,
   parameter int unsigned C_BIT = 0,
   parameter int unsigned Z_BIT = 1,
   parameter int unsigned N_BIT = 2,
   parameter int unsigned V_BIT = 8
) (
   input  logic [2:0]      cond_i,
   input  logic [SR_W-1:0] status_i,
   output logic            take_o
);
   import jmp_eval_pkg::*;

   jflags_t fl;
   jcond_e  cc;

   // Only the four flag positions are read from the status word.
   always_comb begin
      fl.c = status_i[C_BIT];
      fl.z = status_i[Z_BIT];
      fl.n = status_i[N_BIT];
      fl.v = status_i[V_BIT];
   end

   assign cc = jcond_e'(cond_i);

   always_comb begin
      unique case (cc)
         JC_NE:   take_o = ~fl.z;
         JC_EQ:   take_o =  fl.z;
         JC_NC:   take_o = ~fl.c;
         JC_CS:   take_o =  fl.c;
         JC_NEG:  take_o =  fl.n;
         JC_GE:   take_o = ~(fl.n ^ fl.v);
         JC_LT:   take_o =  (fl.n ^ fl.v);
         default: take_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/jmp_target_add.sv
module jmp_target_add #(
   parameter int unsigned PC_W        = 16,
   parameter int unsigned OFS_W       = 10,
   parameter bit          ADDER_SPLIT = 1'b0
) (
   input  logic [PC_W-1:0]  base_i,
   input  logic [OFS_W-1:0] ofs_i,
   output logic [PC_W-1:0]  target_o
);
   localparam int unsigned EXT_W = PC_W - OFS_W - 1;
   localparam int unsigned LO_W  = PC_W / 2;
   localparam int unsigned HI_W  = PC_W - LO_W;

   logic [PC_W-1:0] disp;

   // Sign-extend the word offset and scale it to bytes.
   assign disp = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i, 1'b0};

   generate
      if (ADDER_SPLIT) begin : g_csel
         // Carry select: both upper sums are formed while the lower half settles.
         logic [LO_W:0]   lo_sum;
         logic [HI_W-1:0] hi_c0;
         logic [HI_W-1:0] hi_c1;
         assign lo_sum = {1'b0, base_i[LO_W-1:0]} + {1'b0, disp[LO_W-1:0]};
         assign hi_c0  = base_i[PC_W-1:LO_W] + disp[PC_W-1:LO_W];
         assign hi_c1  = hi_c0 + {{(HI_W-1){1'b0}}, 1'b1};
         assign target_o = {(lo_sum[LO_W] ? hi_c1 : hi_c0), lo_sum[LO_W-1:0]};
      end else begin : g_ripple
         assign target_o = base_i + disp;
      end
   endgenerate

endmodule

// File: rtl/jmp_self_detect.sv
module jmp_self_detect #(
   parameter int unsigned PC_W           = 16,
   parameter int unsigned OFS_W          = 10,
   parameter bit          SELF_BY_OFFSET = 1'b0
) (
   input  logic [PC_W-1:0]  base_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic [PC_W-1:0]  target_i,
   output logic             hit_o
);
   import jmp_eval_pkg::*;

   generate
      if (SELF_BY_OFFSET) begin : g_ofs
         // With a one-word instruction and a short offset, only -1 returns to itself.
         assign hit_o = &ofs_i;
      end else begin : g_addr
         logic [PC_W-1:0] own_addr;
         assign own_addr = base_i - PC_W'(JMP_INSN_BYTES);
         assign hit_o    = (target_i == own_addr);
      end
   endgenerate

endmodule

// File: rtl/jmp_eval.sv
module jmp_eval #(
   parameter int unsigned PC_W           = 16,
   parameter int unsigned OFS_W          = 10,
   parameter int unsigned SR_W           = 16,
   parameter int unsigned C_BIT          = 0,
   parameter int unsigned Z_BIT          = 1,
   parameter int unsigned N_BIT          = 2,
   parameter int unsigned V_BIT          = 8,
   parameter bit          ADDER_SPLIT    = 1'b0,
   parameter bit          SELF_BY_OFFSET = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cond_i,
   input  logic [SR_W-1:0]  status_i,
   input  logic [PC_W-1:0]  pc_next_i,
   input  logic [OFS_W-1:0] offset_i,
   output logic             taken_o,
   output logic [PC_W-1:0]  pc_o,
   output logic             self_loop_o
);

   // Parameter checks at elaboration.
   generate
      if (PC_W < OFS_W + 2) begin : g_bad_width
         $error("jmp_eval: PC_W must exceed OFS_W by at least 2");
      end
      if (PC_W < 4) begin : g_bad_pc
         $error("jmp_eval: PC_W too small");
      end
      if (C_BIT >= SR_W || Z_BIT >= SR_W || N_BIT >= SR_W || V_BIT >= SR_W) begin : g_bad_bit
         $error("jmp_eval: flag position outside status word");
      end
      if (C_BIT == Z_BIT || C_BIT == N_BIT || C_BIT == V_BIT ||
          Z_BIT == N_BIT || Z_BIT == V_BIT || N_BIT == V_BIT) begin : g_dup_bit
         $error("jmp_eval: flag positions must be distinct");
      end
   endgenerate

   logic            take_c;
   logic [PC_W-1:0] target_c;
   logic            hit_c;
   logic [PC_W-1:0] pc_c;

   jmp_cond_decode #(
      .SR_W (SR_W),
      .C_BIT(C_BIT),
      .Z_BIT(Z_BIT),
      .N_BIT(N_BIT),
      .V_BIT(V_BIT)
   ) u_dec (
      .cond_i  (cond_i),
      .status_i(status_i),
      .take_o  (take_c)
   );

   jmp_target_add #(
      .PC_W       (PC_W),
      .OFS_W      (OFS_W),
      .ADDER_SPLIT(ADDER_SPLIT)
   ) u_add (
      .base_i  (pc_next_i),
      .ofs_i   (offset_i),
      .target_o(target_c)
   );

   jmp_self_detect #(
      .PC_W          (PC_W),
      .OFS_W         (OFS_W),
      .SELF_BY_OFFSET(SELF_BY_OFFSET)
   ) u_self (
      .base_i  (pc_next_i),
      .ofs_i   (offset_i),
      .target_i(target_c),
      .hit_o   (hit_c)
   );

   assign pc_c = take_c ? target_c : pc_next_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_o     <= 1'b0;
         pc_o        <= '0;
         self_loop_o <= 1'b0;
      end else begin
         taken_o     <= take_c;
         pc_o        <= pc_c;
         self_loop_o <= take_c & hit_c;
      end
   end

endmodule

// File: rtl/jmp_eval_chk.sv
module jmp_eval_chk #(
   parameter int unsigned PC_W  = 16,
   parameter int unsigned OFS_W = 10,
   parameter int unsigned SR_W  = 16,
   parameter int unsigned C_BIT = 0,
   parameter int unsigned Z_BIT = 1,
   parameter int unsigned N_BIT = 2,
   parameter int unsigned V_BIT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cond_i,
   input logic [SR_W-1:0]  status_i,
   input logic [PC_W-1:0]  pc_next_i,
   input logic [OFS_W-1:0] offset_i,
   input logic             taken_o,
   input logic [PC_W-1:0]  pc_o,
   input logic             self_loop_o
);

   // R3
   eq_follows_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 3'd1) |=> (taken_o == $past(status_i[Z_BIT])));

   // R4
   carry_follows_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 3'd3) |=> (taken_o == $past(status_i[C_BIT])));

   // R5
   neg_follows_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 3'd4) |=> (taken_o == $past(status_i[N_BIT])));

   // R6
   lt_follows_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 3'd6) |=> (taken_o == $past(status_i[N_BIT] ^ status_i[V_BIT])));

   // R7
   always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 3'd7) |=> taken_o);

   // R9
   fallthrough_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (taken_o || pc_o == $past(pc_next_i)));

   // R10
   self_needs_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      self_loop_o |-> taken_o);

   // R10
   self_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (!self_loop_o || pc_o == PC_W'($past(pc_next_i) - PC_W'(2))));

endmodule

bind jmp_eval jmp_eval_chk #(
   .PC_W (PC_W),
   .OFS_W(OFS_W),
   .SR_W (SR_W),
   .C_BIT(C_BIT),
   .Z_BIT(Z_BIT),
   .N_BIT(N_BIT),
   .V_BIT(V_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cond_i     (cond_i),
   .status_i   (status_i),
   .pc_next_i  (pc_next_i),
   .offset_i   (offset_i),
   .taken_o    (taken_o),
   .pc_o       (pc_o),
   .self_loop_o(self_loop_o)
);

// File: tb/jmp_eval_bench.sv
module jmp_eval_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cond_i = '0;
   logic [15:0] status_i = '0;
   logic [15:0] pc_next_i = '0;
   logic [9:0]  offset_i = '0;
   logic        taken_o;
   logic [15:0] pc_o;
   logic        self_loop_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   jmp_eval u_jmp_eval (
      .clk        (clk),
      .rst_n      (rst_n),
      .cond_i     (cond_i),
      .status_i   (status_i),
      .pc_next_i  (pc_next_i),
      .offset_i   (offset_i),
      .taken_o    (taken_o),
      .pc_o       (pc_o),
      .self_loop_o(self_loop_o)
   );

   // Behavioural reference: integer arithmetic on the requirement text.
   function automatic void ref_model(input int cc, input int sr, input int pc, input int ofs,
                                     output int tk, output int npc, output int sl);
      int c, z, n, v, sofs, tgt, own;
      c = sr & 1;
      z = (sr >> 1) & 1;
      n = (sr >> 2) & 1;
      v = (sr >> 8) & 1;
      case (cc)
         0: tk = (z == 0);
         1: tk = (z == 1);
         2: tk = (c == 0);
         3: tk = (c == 1);
         4: tk = (n == 1);
         5: tk = (n == v);
         6: tk = (n != v);
         default: tk = 1;
      endcase
      sofs = (ofs >= 512) ? ofs - 1024 : ofs;
      tgt  = (pc + 2 * sofs + 65536 * 4) % 65536;
      own  = (pc - 2 + 65536) % 65536;
      npc  = tk ? tgt : pc;
      sl   = (tk && tgt == own) ? 1 : 0;
   endfunction

   task automatic apply(input int cc, input int sr, input int pc, input int ofs, input string tag);
      int tk, npc, sl;
      @(negedge clk);
      cond_i    = 3'(cc);
      status_i  = 16'(sr);
      pc_next_i = 16'(pc);
      offset_i  = 10'(ofs);
      ref_model(cc, sr & 16'hFFFF, pc & 16'hFFFF, ofs & 10'h3FF, tk, npc, sl);
      @(posedge clk);
      #1;
      checks++;
      if (int'(taken_o) != tk || int'(pc_o) != npc || int'(self_loop_o) != sl) begin
         errors++;
         $display("FAIL %s: cond=%0d sr=%h pc=%h ofs=%h got taken=%0d pc=%h self=%0d exp taken=%0d pc=%h self=%0d",
                  tag, cc, sr, pc, ofs, taken_o, pc_o, self_loop_o, tk, npc, sl);
      end
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: outputs held at zero during reset
      cond_i    = 3'd7;
      pc_next_i = 16'h1234;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (taken_o !== 1'b0 || pc_o !== 16'h0 || self_loop_o !== 1'b0) begin
         errors++;
         $display("FAIL R1: got taken=%0d pc=%h self=%0d exp 0 0000 0", taken_o, pc_o, self_loop_o);
      end
      @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      checks++;
      if (taken_o !== 1'b0 || pc_o !== 16'h0 || self_loop_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 release: got taken=%0d pc=%h self=%0d exp 0 0000 0", taken_o, pc_o, self_loop_o);
      end

      // R3: Z at bit 1
      apply(0, 16'h0000, 16'h4000, 10, "R3 ne z0");
      apply(0, 16'h0002, 16'h4000, 10, "R3 ne z1");
      apply(1, 16'h0002, 16'h4000, 10, "R3 eq z1");
      apply(1, 16'h0000, 16'h4000, 10, "R3 eq z0");
      // R4: C at bit 0
      apply(2, 16'h0000, 16'h5000, 3, "R4 nc c0");
      apply(2, 16'h0001, 16'h5000, 3, "R4 nc c1");
      apply(3, 16'h0001, 16'h5000, 3, "R4 cs c1");
      apply(3, 16'h0000, 16'h5000, 3, "R4 cs c0");
      // R5: N at bit 2
      apply(4, 16'h0004, 16'h6000, 20, "R5 neg n1");
      apply(4, 16'h0000, 16'h6000, 20, "R5 neg n0");
      // R6: all four N/V pairs
      for (int k = 0; k < 4; k++) begin
         apply(5, ((k & 1) << 2) | ((k >> 1) << 8), 16'h7000, 7, "R6 ge");
         apply(6, ((k & 1) << 2) | ((k >> 1) << 8), 16'h7000, 7, "R6 lt");
      end
      // R7
      apply(7, 16'h0000, 16'h8000, 100, "R7 always");
      apply(7, 16'hFFFF, 16'h8000, 100, "R7 always all flags");
      // R8: offset extremes and wrap
      apply(7, 0, 16'h1000, 10'h200, "R8 min offset");
      apply(7, 0, 16'h1000, 10'h1FF, "R8 max offset");
      apply(7, 0, 16'hFFFE, 1, "R8 wrap up");
      apply(7, 0, 16'h0004, 10'h3F0, "R8 wrap down");
      // R9: not taken keeps pc_next
      apply(1, 0, 16'hABCD, 10'h155, "R9 fallthrough");
      // R10: self loop taken and not taken
      apply(7, 0, 16'h2222, 10'h3FF, "R10 self loop");
      apply(1, 0, 16'h2222, 10'h3FF, "R10 self not taken");
      apply(7, 0, 16'h0000, 10'h3FF, "R10 self at wrap");
      apply(7, 0, 16'h2222, 10'h3FE, "R10 near miss");
      // R11: foreign status bits set, flags clear
      apply(1, 16'hFEF8, 16'h3000, 5, "R11 eq ignores others");
      apply(0, 16'hFEF8, 16'h3000, 5, "R11 ne ignores others");
      apply(5, 16'hFEF8, 16'h3000, 5, "R11 ge ignores others");
      apply(3, 16'hFEF8, 16'h3000, 5, "R11 cs ignores others");
      // R2: back-to-back mixed stimulus, one cycle latency each
      for (int i = 0; i < 600; i++) begin
         apply($urandom % 8, $urandom & 16'hFFFF, $urandom & 16'hFFFF,
               ((i % 7) == 0) ? 10'h3FF : ($urandom & 10'h3FF), "R2 random");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule